// File: doc/BRIEF.md
# Nibble Stack Frame Sequencer

This block moves stack frames between a processor core and a 4-bit-wide data memory. It has one single-port memory interface and transfers one nibble per clock. It owns the 8-bit stack pointer. The stack lives in the lowest 256 nibbles of the address space and grows toward lower addresses.

The core starts an operation by raising `op_valid` with an operation kind and its operands. There are six kinds:

- Register-pair save (kind 0) and restore (kind 1) move two nibbles.
- Subroutine entry (kind 2) and return (kind 3) move a six-nibble frame. The frame holds the return address and the two bank-enable flags.
- Interrupt entry (kind 4) and interrupt return (kind 5) move a six-nibble frame. The frame holds the return address and the whole 8-bit status word.

`busy` is high while an operation runs. `done` pulses for one cycle when the operation completes, and the stack pointer moves in that same cycle. Restore-type operations present their results on `pair_out`, `pc_out` and `stat_out`. These outputs are valid from the `done` cycle until the next operation is accepted.

The stack pointer can be loaded directly while the block is idle. Its bit 0 is forced to zero.

Status word mapping on `psw_in` and `stat_out`:

| Bits | Content |
|---|---|
| [7] | carry |
| [6:4] | skip flags |
| [3:2] | interrupt status |
| [1] | memory-bank enable |
| [0] | register-bank enable |

Top module: `nib_stack_seq`

## Requirements
- R1: After reset, SP is 0x00, `busy` and `done` are 0, and neither `mem_we` nor `mem_re` is asserted.
- R2: SP bit 0 is always 0. When idle, `sp_ld` loads `{sp_ld_val[7:1],0}` on the next edge. A load in the same cycle as `op_valid` wins, and the operation is dropped.
- R3: Kind 0 (pair save) writes `pair_in[7:4]` to SP-1, then `pair_in[3:0]` to SP-2, in the two cycles after acceptance. SP then drops by 2.
- R4: Kind 1 (pair restore) reads SP, then SP+1. Read data arrives on `mem_rdata` the cycle after the request. `pair_out` = {nibble at SP+1, nibble at SP}, and SP rises by 2.
- R5: Kind 2 (subroutine entry) writes six nibbles from SP-1 down to SP-6: 0000, {00,psw_in[1:0]}, {00,PC[13:12]}, PC[11:8], PC[7:4], PC[3:0]. SP then drops by 6.
- R6: Kind 4 (interrupt entry) writes the same frame as R5, except that SP-1 gets `psw_in[7:4]` and SP-2 gets `psw_in[3:0]`. SP drops by 6.
- R7: Kind 3 (subroutine return) reads SP..SP+5 in ascending order. `pc_out` = {bits[1:0] of SP+3, SP+2, SP+1, SP}. `stat_out` = {000000, bits[1:0] of SP+4}. SP rises by 6.
- R8: Kind 5 (interrupt return) reads like R7, but `stat_out` = {nibble at SP+5, nibble at SP+4}.
- R9: Timing rules:
  - A write operation of N nibbles keeps `busy` high for N cycles; a read operation keeps it high for N+1 cycles.
  - `done` is a one-cycle pulse in the first idle cycle.
  - SP changes only at the edge that raises `done`.
  - Read and write are never both asserted.
- R10: While `busy` is high, `op_valid` and `sp_ld` are ignored. Kinds 6 and 7 are never accepted. While idle, no memory access is made.
- R11: SP and all stack addresses wrap modulo 256. `mem_addr[11:8]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_kind | input | 3 | Operation kind, 0..5 |
| pair_in | input | 8 | Register pair to save |
| pc_in | input | PC_W | Return address to save |
| psw_in | input | 8 | Status word to save |
| sp_ld | input | 1 | Load stack pointer |
| sp_ld_val | input | 8 | Value for the stack pointer load |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 8 | Stack pointer |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Nibble address |
| mem_wdata | output | 4 | Write data |
| mem_rdata | input | 4 | Read data, one cycle after `mem_re` |
| pair_out | output | 8 | Restored register pair |
| pc_out | output | PC_W | Restored return address |
| stat_out | output | 8 | Restored status or flags |

## Verification
A wrong step count or a wrong alignment of the stack pointer shows up at the `done` edge, in the same cycle, as an SP value off by 2 or 4. It also shows on the address bus of the next operation.

A wrong nibble index or a wrong address direction appears at once on `mem_addr` or `mem_wdata`, in the first transfer cycle. On restore it appears at `done` as swapped or shifted fields in `pair_out`, `pc_out` or `stat_out`.

A reference model in the bench predicts every port on every cycle. Any divergence is therefore reported in the cycle where it first reaches a pin.

// File: rtl/nib_stack_seq.sv
module nib_stack_seq #(
  parameter int PC_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_kind,
  input  logic [7:0]      pair_in,
  input  logic [PC_W-1:0] pc_in,
  input  logic [7:0]      psw_in,
  input  logic            sp_ld,
  input  logic [7:0]      sp_ld_val,
  output logic            busy,
  output logic            done,
  output logic [7:0]      sp,
  output logic            mem_re,
  output logic            mem_we,
  output logic [11:0]     mem_addr,
  output logic [3:0]      mem_wdata,
  input  logic [3:0]      mem_rdata,
  output logic [7:0]      pair_out,
  output logic [PC_W-1:0] pc_out,
  output logic [7:0]      stat_out
);

  localparam logic [2:0] K_PUSH = 3'd0, K_POP = 3'd1, K_CALL = 3'd2,
                         K_RET  = 3'd3, K_INT = 3'd4, K_IRET = 3'd5;

  logic [2:0]  kind, cnt;
  logic [7:0]  sp_q;
  logic [23:0] wbuf, rbuf, wnew;

  wire        is_rd   = (kind == K_POP) || (kind == K_RET) || (kind == K_IRET);
  wire        short_op = (kind == K_PUSH) || (kind == K_POP);
  wire [2:0]  len     = short_op ? 3'd2 : 3'd6;
  wire [2:0]  last    = is_rd ? len : len - 3'd1;
  wire        finish  = busy && (cnt == last);
  wire        accept  = !busy && !sp_ld && op_valid && (op_kind <= K_IRET);
  wire [7:0]  delta   = short_op ? 8'd2 : 8'd6;
  wire [7:0]  sp_next = is_rd ? sp_q + delta : sp_q - delta;
  wire        xfer    = busy && (cnt < len);
  wire [7:0]  off     = is_rd ? sp_q + {5'd0, cnt} : sp_q - 8'd1 - {5'd0, cnt};
  wire [13:0] pcx     = 14'(pc_in);
  wire [23:0] wsh     = wbuf >> {cnt, 2'b00};
  wire [2:0]  cm1     = cnt - 3'd1;
  wire [13:0] pc_full = {rbuf[13:12], rbuf[11:0]};

  assign sp        = sp_q;
  assign mem_we    = xfer && !is_rd;
  assign mem_re    = xfer && is_rd;
  assign mem_addr  = {4'h0, off};
  assign mem_wdata = wsh[3:0];
  assign pair_out  = rbuf[7:0];
  assign pc_out    = pc_full[PC_W-1:0];
  assign stat_out  = (kind == K_RET) ? {6'd0, rbuf[17:16]} : rbuf[23:16];

  always_comb begin
    case (op_kind)
      K_PUSH:  wnew = {16'h0, pair_in[3:0], pair_in[7:4]};
      K_CALL:  wnew = {pcx[3:0], pcx[7:4], pcx[11:8], 2'b00, pcx[13:12],
                       2'b00, psw_in[1:0], 4'h0};
      K_INT:   wnew = {pcx[3:0], pcx[7:4], pcx[11:8], 2'b00, pcx[13:12],
                       psw_in[3:0], psw_in[7:4]};
      default: wnew = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      kind <= K_PUSH;
      sp_q <= '0;
      wbuf <= '0;
      rbuf <= '0;
    end else begin
      done <= finish;
      if (!busy) begin
        if (sp_ld) begin
          sp_q <= {sp_ld_val[7:1], 1'b0};
        end else if (accept) begin
          busy <= 1'b1;
          cnt  <= '0;
          kind <= op_kind;
          wbuf <= wnew;
        end
      end else begin
        if (finish) begin
          busy <= 1'b0;
          sp_q <= sp_next;
        end else begin
          cnt <= cnt + 3'd1;
        end
        if (is_rd && cnt != 3'd0) rbuf[{cm1, 2'b00} +: 4] <= mem_rdata;
      end
    end
  end

  // R2
  sp_even_chk: assert property (@(posedge clk) disable iff (!rst_n) sp[0] == 1'b0);
  // R2
  sp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_ld && !busy) |=> sp == {$past(sp_ld_val[7:1]), 1'b0});
  // R9
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R9
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (done || $stable(sp)));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !(mem_we || mem_re));

endmodule

// File: tb/nib_stack_seq_test.sv
module nib_stack_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        op_valid = 0, sp_ld = 0;
  logic [2:0]  op_kind = 0;
  logic [7:0]  pair_in = 0, psw_in = 0, sp_ld_val = 0;
  logic [13:0] pc_in = 0;
  logic        busy, done, mem_re, mem_we;
  logic [7:0]  sp, pair_out, stat_out;
  logic [11:0] mem_addr;
  logic [3:0]  mem_wdata, mem_rdata;
  logic [13:0] pc_out;
  logic [3:0]  ram [0:255];

  nib_stack_seq #(.PC_W(14)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .pair_in(pair_in), .pc_in(pc_in), .psw_in(psw_in), .sp_ld(sp_ld),
    .sp_ld_val(sp_ld_val), .busy(busy), .done(done), .sp(sp),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pair_out(pair_out),
    .pc_out(pc_out), .stat_out(stat_out));

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
  end

  int checks = 0, errors = 0;
  bit finished = 0;
  bit mb = 0, md = 0, mrd = 0;
  int msp = 0, mk = 0, mstep = 0, mlen = 2, mdelta = 2;
  int mwn [6];
  int e_pair = 0, e_pc = 0, e_stat = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int k);
    case (k)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R7";
      4: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic compare();
    chk("R9", "busy", busy, mb);
    chk("R9", "done", done, md);
    chk("R2", "sp", sp, msp);
    if (mb && mstep < mlen) begin
      chk(tag_of(mk), "we", mem_we, !mrd);
      chk(tag_of(mk), "re", mem_re, mrd);
      chk(tag_of(mk), "addr", mem_addr[7:0],
          mrd ? (msp + mstep) & 255 : (msp - 1 - mstep) & 255);
      chk("R11", "addr upper", mem_addr[11:8], 0);
      if (!mrd) chk(tag_of(mk), "wdata", mem_wdata, mwn[mstep]);
    end else begin
      chk("R10", "no access", mem_we | mem_re, 0);
    end
    if (md && mrd) begin
      if (mk == 1) chk("R4", "pair_out", pair_out, e_pair);
      else begin
        chk(tag_of(mk), "pc_out", pc_out, e_pc);
        chk(tag_of(mk), "stat_out", stat_out, e_stat);
      end
    end
  endtask

  task automatic step(bit v, int k, int pr, int pc, int ps, bit ld, int lv);
    op_valid = v; op_kind = 3'(k); pair_in = 8'(pr); pc_in = 14'(pc);
    psw_in = 8'(ps); sp_ld = ld; sp_ld_val = 8'(lv);
    if (mb) begin
      if (mstep == (mrd ? mlen : mlen - 1)) begin
        mb = 0; md = 1;
        msp = (mrd ? msp + mdelta : msp - mdelta) & 255;
      end else begin
        mstep++; md = 0;
      end
    end else begin
      md = 0;
      if (ld) msp = lv & 8'hFE;
      else if (v && k <= 5) begin
        mb = 1; mstep = 0; mk = k;
        mlen = (k < 2) ? 2 : 6; mdelta = mlen;
        mrd = (k == 1 || k == 3 || k == 5);
        if (k == 0) begin
          mwn[0] = (pr >> 4) & 15; mwn[1] = pr & 15;
        end else if (k == 2 || k == 4) begin
          mwn[0] = (k == 4) ? (ps >> 4) & 15 : 0;
          mwn[1] = (k == 4) ? ps & 15 : ps & 3;
          mwn[2] = (pc >> 12) & 3; mwn[3] = (pc >> 8) & 15;
          mwn[4] = (pc >> 4) & 15; mwn[5] = pc & 15;
        end else begin
          int r [6];
          for (int i = 0; i < 6; i++) r[i] = ram[(msp + i) & 255];
          e_pair = (r[1] << 4) | r[0];
          e_pc = ((r[3] & 3) << 12) | (r[2] << 8) | (r[1] << 4) | r[0];
          e_stat = (k == 3) ? (r[4] & 3) : ((r[5] << 4) | r[4]);
        end
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    while (mb) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic op(int k, int pr, int pc, int ps);
    step(1, k, pr, pc, ps, 0, 0);
    idle();
  endtask

  task automatic load(int v);
    step(0, 0, 0, 0, 0, 1, v);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 4'((i * 7 + 3) & 15);
    repeat (3) @(negedge clk);
    chk("R1", "reset sp", sp, 0);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset access", mem_we | mem_re, 0);
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0);

    load(8'h35);
    chk("R2", "odd load", sp, 8'h34);
    load(8'h00);
    op(0, 8'hA5, 0, 0);
    chk("R11", "wrap below zero", sp, 8'hFE);
    op(0, 8'h3C, 0, 0);
    op(1, 0, 0, 0);
    chk("R4", "pop order", pair_out, 8'h3C);
    op(1, 0, 0, 0);
    chk("R4", "pop wrap", pair_out, 8'hA5);
    chk("R11", "wrap above top", sp, 8'h00);

    load(8'h40);
    op(2, 0, 14'h2ABC, 8'hF7);
    chk("R5", "call sp", sp, 8'h3A);
    op(3, 0, 0, 0);
    chk("R7", "ret pc", pc_out, 14'h2ABC);
    chk("R7", "ret flags", stat_out, 8'h03);
    op(4, 0, 14'h1234, 8'h9E);
    op(5, 0, 0, 0);
    chk("R8", "iret pc", pc_out, 14'h1234);
    chk("R8", "iret status", stat_out, 8'h9E);

    step(1, 2, 0, 14'h0F0F, 8'h02, 0, 0);
    step(1, 1, 0, 0, 0, 1, 8'h80);
    step(1, 0, 8'hFF, 0, 0, 0, 0);
    idle();
    chk("R10", "busy ignores", sp, 8'h3A);
    op(3, 0, 0, 0);
    chk("R10", "ret after ignored", pc_out, 14'h0F0F);

    step(1, 6, 0, 0, 0, 0, 0);
    chk("R10", "kind 6 busy", busy, 0);
    step(1, 7, 0, 0, 0, 0, 0);
    chk("R10", "kind 7 busy", busy, 0);
    step(1, 0, 8'h11, 0, 0, 1, 8'h21);
    chk("R2", "load wins busy", busy, 0);
    chk("R2", "load wins sp", sp, 8'h20);

    load(8'h02);
    op(2, 0, 14'h3FFF, 8'h01);
    chk("R11", "call wrap", sp, 8'hFC);
    op(3, 0, 0, 0);
    chk("R7", "ret across wrap", pc_out, 14'h3FFF);

    for (int n = 0; n < 400; n++) begin
      int k;
      k = int'($urandom % 9);
      if (k == 8) load(int'($urandom % 256));
      else op(k, int'($urandom % 256), int'($urandom % 16384), int'($urandom % 256));
      if (($urandom % 4) == 0) step(0, 0, 0, 0, 0, 0, 0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule